// File: doc/BRIEF.md
# Three-Source Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and takes interrupt requests from three sources. The sources are a falling edge on an external request pin, a one-cycle timer overflow pulse and a one-cycle end-of-conversion pulse from an analogue converter. It holds one 8-bit control register. The register has a master enable, one enable per source and one pending flag per source. The core reads and writes it through a simple port.

Pending requests are only considered on the rising edge of a sampling strobe that the core supplies. At that instant the block can accept a request: the master enable must be set, the stack must not be full and at least one enabled source must be pending. It then picks one source by fixed priority and clears that source's flag. It also clears the master enable, so a second interrupt cannot be taken inside the service routine. For the next cycle it presents a one-cycle call request together with the vector address of the chosen source.

On return the core reports the return type. A return-from-interrupt sets the master enable again. A plain return leaves it as it is.

The arbiter is a three-state machine:
- `ST_IDLE`: nothing accepted. It goes to `ST_CALL` on an accepted request (transition *grant*). It goes to `ST_BLOCKED` when an enabled request is pending with the master enable set but the stack is full (transition *stall*).
- `ST_BLOCKED`: it goes to `ST_CALL` on *grant*. It goes back to `ST_IDLE` once the stall condition is gone (transition *release*).
- `ST_CALL`: the call request is asserted for this one cycle. It then always goes back to `ST_IDLE` (transition *done*).

Top module: `vint3_top`

## Requirements
- R1: After reset the control register reads 0x00, `irq_call` is low and `wake` is low.
- R2: Control register layout:
  - bit 0 is the master enable;
  - bits 1, 2 and 3 enable the external, timer and conversion sources;
  - bits 4, 5 and 6 are the external, timer and conversion pending flags;
  - bit 7 always reads 0.
  A write takes effect at the clock edge where `reg_we` is high. Writing a flag bit to 1 raises a request.
- R3: The external flag (bit 4) is set at the clock edge where `ext_pin` is first seen low after being high. A low-to-high change sets nothing.
- R4: A high `tmr_ovf` at a clock edge sets bit 5. A high `adc_eoc` at a clock edge sets bit 6.
- R5: A request is accepted only at a clock edge where `smp_strobe` is high and was low at the previous edge. At that edge the master enable must be 1, `stk_full` must be 0, and some flag must be set together with its own enable. The cycle after that edge has `irq_call` high for exactly one cycle. In that cycle `irq_vector` is 0x04 for external, 0x08 for timer and 0x0C for conversion.
- R6: When several enabled requests are pending, the external source wins over the timer, and the timer wins over conversion.
- R7: Acceptance clears the flag of the serviced source and the master enable. The other flags are left unchanged.
- R8: A flag set while the master enable is 0 stays set. It is serviced at the first qualifying strobe edge after the enable is set.
- R9: While `stk_full` is 1, no request is accepted, and the flags and register are left unchanged.
- R10: A return with `ret_is_reti`=1 sets the master enable, and this overrides a register write in the same cycle. A return with `ret_is_reti`=0 leaves it unchanged.
- R11: A hardware set of a flag wins over a software write of 0 to that flag in the same cycle.
- R12: `wake` is high whenever any of the three flags is set, whatever the enables.
- R13: A strobe held high produces at most one acceptance. A new rising edge is needed for the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control register write enable |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| ext_pin | input | 1 | External request pin, active on falling edge |
| tmr_ovf | input | 1 | Timer overflow pulse |
| adc_eoc | input | 1 | End-of-conversion pulse |
| stk_full | input | 1 | Hardware stack is full |
| smp_strobe | input | 1 | Sampling strobe, acted on at its rising edge |
| ret_valid | input | 1 | Core executes a return this cycle |
| ret_is_reti | input | 1 | The return is a return-from-interrupt |
| irq_call | output | 1 | One-cycle call request to the core |
| irq_vector | output | 8 | Vector address, valid with `irq_call` |
| wake | output | 1 | Any request flag pending |

## Verification
Corruption of a flag or enable bit shows on `reg_rdata` at the very next sample. It then shows on `wake`, or on a missing or extra call, at the next strobe edge.

A wrong arbiter state or a wrong priority pick shows as a misplaced `irq_call` or a wrong `irq_vector` in the cycle after the strobe edge. A missed clear shows as a repeated call once the master enable returns.

The bench compares every port against a behavioural model on every clock, so any of these faults is reported within one cycle of its first visible effect.

// File: rtl/vint3_pkg.sv
package vint3_pkg;

    // number of request sources; index order is also priority order
    localparam int NSRC = 3;

    localparam int SRC_EXT = 0;
    localparam int SRC_TMR = 1;
    localparam int SRC_ADC = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BLOCKED = 2'd1,
        ST_CALL    = 2'd2
    } arb_state_t;

endpackage

// File: rtl/vint3_edge.sv
module vint3_edge #(
    parameter bit FALLING    = 1'b0,
    parameter bit IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic hit
);

    logic din_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= IDLE_LEVEL;
        end else begin
            din_q <= din;
        end
    end

    generate
        if (FALLING) begin : g_fall
            assign hit = din_q & ~din;
        end else begin : g_rise
            assign hit = din & ~din_q;
        end
    endgenerate

endmodule

// File: rtl/vint3_regs.sv
module vint3_regs #(
    parameter int DW   = 8,
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [DW-1:0]   wdata,
    input  logic [NSRC-1:0] hw_set,
    input  logic            ack_valid,
    input  logic [NSRC-1:0] ack_sel,
    input  logic            reti,
    output logic            gen,
    output logic [NSRC-1:0] en,
    output logic [NSRC-1:0] flag,
    output logic [DW-1:0]   rdata
);

    localparam int EN_LSB = 1;
    localparam int FL_LSB = EN_LSB + NSRC;
    localparam int USED   = FL_LSB + NSRC;

    logic            gen_n;
    logic [NSRC-1:0] en_n;
    logic [NSRC-1:0] flag_n;

    // ordering: software write, then return rule, then acknowledge, then hardware set
    always_comb begin
        gen_n  = gen;
        en_n   = en;
        flag_n = flag;
        if (we) begin
            gen_n  = wdata[0];
            en_n   = wdata[EN_LSB +: NSRC];
            flag_n = wdata[FL_LSB +: NSRC];
        end
        if (reti) begin
            gen_n = 1'b1;
        end
        if (ack_valid) begin
            gen_n  = 1'b0;
            flag_n = flag_n & ~ack_sel;
        end
        flag_n = flag_n | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen  <= 1'b0;
            en   <= '0;
            flag <= '0;
        end else begin
            gen  <= gen_n;
            en   <= en_n;
            flag <= flag_n;
        end
    end

    always_comb begin
        rdata                   = '0;
        rdata[0]                = gen;
        rdata[EN_LSB +: NSRC]   = en;
        rdata[FL_LSB +: NSRC]   = flag;
    end

    initial begin
        if (USED > DW) $error("control register too narrow");
    end

endmodule

// File: rtl/vint3_arb.sv
module vint3_arb
    import vint3_pkg::*;
#(
    parameter int DW       = 8,
    parameter int NSRC     = 3,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe_rise,
    input  logic            stk_full,
    input  logic            gen,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] flag,
    output logic            ack_valid,
    output logic [NSRC-1:0] ack_sel,
    output logic            call,
    output logic [DW-1:0]   vector
);

    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    arb_state_t      state, state_n;
    logic [NSRC-1:0] live;
    logic            any_live;
    logic [IW-1:0]   pick_idx;
    logic [NSRC-1:0] pick_sel;
    logic            stall;
    logic [DW-1:0]   vec_q;
    logic [DW-1:0]   vec_n;

    assign live     = en & flag;
    assign any_live = |live;

    // fixed priority: lowest index wins, so scan downwards
    always_comb begin
        pick_idx = '0;
        pick_sel = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (live[i]) begin
                pick_idx = IW'(i);
                pick_sel = NSRC'(1) << i;
            end
        end
    end

    assign vec_n = DW'(VEC_BASE + int'(pick_idx) * VEC_STEP);

    assign stall     = gen & any_live & stk_full;
    assign ack_valid = strobe_rise & gen & any_live & ~stk_full & (state != ST_CALL);
    assign ack_sel   = ack_valid ? pick_sel : '0;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (ack_valid)  state_n = ST_CALL;
                else if (stall) state_n = ST_BLOCKED;
            end
            ST_BLOCKED: begin
                if (ack_valid)   state_n = ST_CALL;
                else if (!stall) state_n = ST_IDLE;
            end
            ST_CALL: begin
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            vec_q <= '0;
        end else begin
            state <= state_n;
            if (ack_valid) vec_q <= vec_n;
        end
    end

    // outputs
    always_comb begin
        call   = (state == ST_CALL);
        vector = vec_q;
    end

endmodule

// File: rtl/vint3_top.sv
module vint3_top
    import vint3_pkg::*;
#(
    parameter int DW       = 8,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          ext_pin,
    input  logic          tmr_ovf,
    input  logic          adc_eoc,
    input  logic          stk_full,
    input  logic          smp_strobe,
    input  logic          ret_valid,
    input  logic          ret_is_reti,
    output logic          irq_call,
    output logic [DW-1:0] irq_vector,
    output logic          wake
);

    logic            ext_fall;
    logic            strobe_rise;
    logic [NSRC-1:0] hw_set;
    logic            ack_valid;
    logic [NSRC-1:0] ack_sel;
    logic            gen;
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] flag;

    vint3_edge #(.FALLING(1'b1), .IDLE_LEVEL(1'b1)) u_pin_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_pin),
        .hit   (ext_fall)
    );

    vint3_edge #(.FALLING(1'b0), .IDLE_LEVEL(1'b0)) u_strobe_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (smp_strobe),
        .hit   (strobe_rise)
    );

    always_comb begin
        hw_set          = '0;
        hw_set[SRC_EXT] = ext_fall;
        hw_set[SRC_TMR] = tmr_ovf;
        hw_set[SRC_ADC] = adc_eoc;
    end

    vint3_regs #(.DW(DW), .NSRC(NSRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .wdata     (reg_wdata),
        .hw_set    (hw_set),
        .ack_valid (ack_valid),
        .ack_sel   (ack_sel),
        .reti      (ret_valid & ret_is_reti),
        .gen       (gen),
        .en        (en),
        .flag      (flag),
        .rdata     (reg_rdata)
    );

    vint3_arb #(.DW(DW), .NSRC(NSRC), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_rise (strobe_rise),
        .stk_full    (stk_full),
        .gen         (gen),
        .en          (en),
        .flag        (flag),
        .ack_valid   (ack_valid),
        .ack_sel     (ack_sel),
        .call        (irq_call),
        .vector      (irq_vector)
    );

    assign wake = |flag;

endmodule

// File: rtl/vint3_chk.sv
module vint3_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] reg_rdata,
    input logic          stk_full,
    input logic          smp_strobe,
    input logic          irq_call,
    input logic [DW-1:0] irq_vector,
    input logic          wake
);

    p_call_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_call |=> !irq_call);

    p_call_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_call) |-> $past(smp_strobe));

    p_vector_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_call |-> (irq_vector == DW'(4) || irq_vector == DW'(8) || irq_vector == DW'(12)));

    p_gen_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_call |-> !reg_rdata[0]);

    p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_call) |-> $past(!stk_full && reg_rdata[0]));

    p_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_call && irq_vector != DW'(4)) |-> !$past(reg_rdata[4] && reg_rdata[1]));

    p_top_bit_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[7]);

    p_wake_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wake == (|reg_rdata[6:4]));

endmodule

bind vint3_top vint3_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rdata  (reg_rdata),
    .stk_full   (stk_full),
    .smp_strobe (smp_strobe),
    .irq_call   (irq_call),
    .irq_vector (irq_vector),
    .wake       (wake)
);

// File: tb/sim_vint3_top.sv
`timescale 1ns/1ps
module sim_vint3_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ext_pin = 1'b1;
    logic       tmr_ovf = 1'b0;
    logic       adc_eoc = 1'b0;
    logic       stk_full = 1'b0;
    logic       smp_strobe = 1'b0;
    logic       ret_valid = 1'b0;
    logic       ret_is_reti = 1'b0;
    logic       irq_call;
    logic [7:0] irq_vector;
    logic       wake;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    vint3_top u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .ext_pin     (ext_pin),
        .tmr_ovf     (tmr_ovf),
        .adc_eoc     (adc_eoc),
        .stk_full    (stk_full),
        .smp_strobe  (smp_strobe),
        .ret_valid   (ret_valid),
        .ret_is_reti (ret_is_reti),
        .irq_call    (irq_call),
        .irq_vector  (irq_vector),
        .wake        (wake)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [7:0] m_reg;
    bit       m_pin_q, m_stb_q, m_call, m_on;
    bit [7:0] m_vec;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = 8'h00; m_pin_q = 1'b1; m_stb_q = 1'b0;
            m_call = 1'b0; m_vec = 8'h00; m_on = 1'b1;
        end else begin
            bit [7:0] nr;
            bit grant;
            int src;
            nr = m_reg;
            src = -1;
            for (int k = 2; k >= 0; k--)
                if (m_reg[4+k] && m_reg[1+k]) src = k;
            grant = smp_strobe && !m_stb_q && m_reg[0] && !stk_full && !m_call && src >= 0;
            if (reg_we) nr = reg_wdata & 8'h7F;
            if (ret_valid && ret_is_reti) nr[0] = 1'b1;
            if (grant) begin
                nr[0] = 1'b0;
                nr[4+src] = 1'b0;
            end
            if (m_pin_q && !ext_pin) nr[4] = 1'b1;
            if (tmr_ovf) nr[5] = 1'b1;
            if (adc_eoc) nr[6] = 1'b1;
            m_call = grant;
            if (grant) m_vec = 8'(4 + 4 * src);
            m_reg = nr;
            m_pin_q = ext_pin;
            m_stb_q = smp_strobe;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && m_on && !done) begin
            chk("R2 model register", reg_rdata, m_reg);
            chk("R5 model call", irq_call, m_call);
            if (m_call) chk("R6 model vector", irq_vector, m_vec);
            chk("R12 model wake", wake, |m_reg[6:4]);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        reg_we = 1'b1; reg_wdata = v;
        step();
        reg_we = 1'b0;
    endtask

    task automatic strobe_pulse();
        smp_strobe = 1'b1;
        step();
        smp_strobe = 1'b0;
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 reset register", reg_rdata, 8'h00);
        chk("R1 reset call", irq_call, 0);
        chk("R1 reset wake", wake, 0);

        // R2 layout and bit 7
        wr(8'h0F);
        chk("R2 enables write", reg_rdata, 8'h0F);
        wr(8'hFF);
        chk("R2 bit7 zero", reg_rdata, 8'h7F);
        chk("R12 wake all flags", wake, 1);
        wr(8'h00);
        chk("R2 clear", reg_rdata, 8'h00);

        // R3 external falling edge
        ext_pin = 1'b0; step();
        chk("R3 fall sets bit4", reg_rdata, 8'h10);
        wr(8'h00);
        ext_pin = 1'b1; step();
        chk("R3 rise ignored", reg_rdata, 8'h00);

        // R4 timer and conversion pulses
        tmr_ovf = 1'b1; step(); tmr_ovf = 1'b0;
        chk("R4 timer sets bit5", reg_rdata, 8'h20);
        adc_eoc = 1'b1; step(); adc_eoc = 1'b0;
        chk("R4 conv sets bit6", reg_rdata, 8'h60);

        // R6 / R7 priority and acknowledge
        wr(8'h0F);
        ext_pin = 1'b0; tmr_ovf = 1'b1; adc_eoc = 1'b1; step();
        tmr_ovf = 1'b0; adc_eoc = 1'b0;
        chk("R6 all pending", reg_rdata, 8'h7F);
        strobe_pulse();
        chk("R5 call raised", irq_call, 1);
        chk("R6 external first", irq_vector, 8'h04);
        chk("R7 flag and gen cleared", reg_rdata, 8'h6E);
        step();
        chk("R5 call one cycle", irq_call, 0);
        ext_pin = 1'b1;
        // R10 plain return keeps gen off
        ret_valid = 1'b1; ret_is_reti = 1'b0; step(); ret_valid = 1'b0;
        chk("R10 plain return", reg_rdata, 8'h6E);
        strobe_pulse();
        chk("R8 held while disabled", irq_call, 0);
        ret_valid = 1'b1; ret_is_reti = 1'b1; step(); ret_valid = 1'b0; ret_is_reti = 1'b0;
        chk("R10 reti sets gen", reg_rdata, 8'h6F);
        strobe_pulse();
        chk("R6 timer second", irq_vector, 8'h08);
        chk("R7 timer cleared", reg_rdata, 8'h4E);
        step();
        ret_valid = 1'b1; ret_is_reti = 1'b1; step(); ret_valid = 1'b0; ret_is_reti = 1'b0;
        strobe_pulse();
        chk("R6 conversion third", irq_vector, 8'h0C);
        chk("R12 wake drops", wake, 0);
        step();

        // R9 stack full blocks
        wr(8'h2F);
        stk_full = 1'b1;
        strobe_pulse();
        chk("R9 no call when full", irq_call, 0);
        chk("R9 register untouched", reg_rdata, 8'h2F);
        stk_full = 1'b0; step();
        chk("R5 no call without strobe", irq_call, 0);
        strobe_pulse();
        chk("R9 served after release", irq_vector, 8'h08);
        step();

        // R13 strobe held high
        wr(8'h2F);
        smp_strobe = 1'b1; step();
        chk("R13 first call", irq_call, 1);
        step();
        wr(8'h2F);
        step();
        chk("R13 no second call", irq_call, 0);
        smp_strobe = 1'b0; step();
        strobe_pulse();
        chk("R13 new edge calls", irq_call, 1);
        step();

        // R11 hardware set beats software clear
        reg_we = 1'b1; reg_wdata = 8'h08; adc_eoc = 1'b1; step();
        reg_we = 1'b0; adc_eoc = 1'b0;
        chk("R11 hw set wins", reg_rdata, 8'h48);
        // R8 serviced once enabled
        strobe_pulse();
        chk("R8 no call gen off", irq_call, 0);
        wr(8'h49);
        strobe_pulse();
        chk("R8 served after enable", irq_vector, 8'h0C);
        step();

        // R10 reti overrides write
        reg_we = 1'b1; reg_wdata = 8'h00; ret_valid = 1'b1; ret_is_reti = 1'b1; step();
        reg_we = 1'b0; ret_valid = 1'b0; ret_is_reti = 1'b0;
        chk("R10 reti over write", reg_rdata, 8'h01);

        // R5 / R12 flag without its enable
        wr(8'h41);
        strobe_pulse();
        chk("R5 disabled source ignored", irq_call, 0);
        chk("R12 wake ignores enables", wake, 1);
        step();

        finish_up();
    end

endmodule